// File: doc/BRIEF.md
# Two-Channel DMA Engine

This block moves data between peripheral devices and a simple memory bus on behalf of software. It has two independent channels. Each channel has an address register, a count register and a command register, and each exposes a read-only status word. Software loads the start address first, then the transfer count minus one, and then writes a command word whose top bit starts the channel. From that point the channel runs on its own. Each time its device signals that it is ready, the channel performs one byte, halfword or word access on the memory bus. At the end of the run it flags a pending interrupt.

The two channels share one memory port through a request/grant handshake. When both want the port in the same cycle, a fixed arbiter decides which one goes first. Each channel can flag three faults: a misaligned start address, a bus error reported by memory, and address roll-over past the top of the address space. A merged interrupt output carries the most urgent pending level. Software acknowledges a channel's interrupt by reading that channel's address register.

Top module: `dma2ch_engine`

## Requirements
- R1: Register select uses reg_addr[2] to pick the channel and reg_addr[1:0] to pick the register: 0 address, 1 count, 2 status, 3 command. Read data appears on reg_rdata the cycle after reg_rd. After reset every register and status bit reads zero, and mem_req and irq are low.
- R2: Writing the command register with bit 15 set arms the channel (status bit 0). The same write clears pending, halt, bus-error, alignment and wrap. A command write with bit 15 clear disarms the channel. Writes to address or count are ignored while the channel is armed.
- R3: A loaded count of N performs exactly N+1 transfers. The count register reads 0 once the run ends.
- R4: Command bit 8 selects word (4 bytes) and takes precedence over bit 1, which selects halfword (2 bytes). With neither bit set the size is a byte. mem_size carries 0, 1 or 2 for byte, halfword or word. The address advances by 1, 2 or 4 after each transfer.
- R5: With command bit 2 set, the channel writes memory (mem_we=1) using the channel's dev_din lane as mem_wdata. With bit 2 clear it reads memory and returns mem_rdata on dev_dout. Either way, each completed transfer pulses that channel's dev_ack for one cycle.
- R6: mem_req stays high with a stable address until mem_gnt is seen, and mem_gnt completes exactly one transfer. mem_req is low in the cycle after a grant.
- R7: When the last transfer ends, armed clears and status bit 1 (pending) sets. irq rises only if command bit 0 (enable) is set.
- R8: Command bits 5:4 hold the interrupt level minus 3, so irq_level reports 3 to 6. With several enabled channels pending, irq_level shows the highest level; on equal levels the lower channel's level is shown.
- R9: A read of a channel's address register clears that channel's pending bit, and irq follows one cycle later.
- R10: A halfword start address with bit 0 set, or a word start address with bits 1:0 nonzero, makes no memory access. It sets status bit 5 (alignment), bit 3 (halt) and pending, and clears armed.
- R11: mem_err together with mem_grant-complete sets status bit 4 (bus error), bit 3 (halt) and pending. It clears armed, leaves the address unadvanced and gives no dev_ack.
- R12: When an address advance carries out of the top bit, status bit 6 (wrap) sets and the run continues from the wrapped address.
- R13: When both channels are ready together, a channel with command bit 3 (priority) set goes first. On equal priority, channel 0 goes first.
- R14: Status bit 2 is high while that channel's memory request is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Channel and register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_rd |
| dev_rdy | input | 2 | Per-channel device ready |
| dev_din | input | 64 | Per-channel device data, channel 0 in the low lane |
| dev_ack | output | 2 | Per-channel transfer-done pulse |
| dev_dout | output | 32 | Data read from memory for the device |
| mem_req | output | 1 | Memory request |
| mem_addr | output | 32 | Memory byte address |
| mem_we | output | 1 | Memory write when high |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Grant; completes the access |
| mem_err | input | 1 | Bus error, valid with mem_gnt |
| mem_rdata | input | 32 | Memory read data, valid with mem_gnt |
| irq | output | 1 | Merged interrupt |
| irq_level | output | 3 | Level of the most urgent pending channel |

## Verification
Several properties are checked on every cycle:
- every issued memory access is aligned to its size code;
- a request holds its address and direction until granted, and drops right after the grant;
- a device acknowledge follows only an error-free grant and is never given to both channels at once;
- the interrupt level stays within 3 to 6.

Other behaviour can only be shown by the bench's scenarios. These cover the count-minus-one run length, address stepping and wrap, and the fault flags with their effect on the address. They also cover arbitration order, level merging, interrupt acknowledge by address read, and write protection of an armed channel.

// File: rtl/dma2_pkg.sv
package dma2_pkg;
  // command word bit positions
  localparam int CMD_EN   = 0;
  localparam int CMD_HALF = 1;
  localparam int CMD_TOMEM = 2;
  localparam int CMD_PRI  = 3;
  localparam int CMD_LVL  = 4;
  localparam int CMD_WORD = 8;
  localparam int CMD_GO   = 15;
  localparam int CMD_W    = 16;

  // status word bit positions
  localparam int ST_ARMED = 0;
  localparam int ST_PEND  = 1;
  localparam int ST_BUSY  = 2;
  localparam int ST_HALT  = 3;
  localparam int ST_BERR  = 4;
  localparam int ST_ALIGN = 5;
  localparam int ST_WRAP  = 6;
  localparam int ST_W     = 7;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2} xsize_e;
  typedef enum logic {SEQ_IDLE = 1'b0, SEQ_ACCESS = 1'b1} seq_e;

  function automatic xsize_e size_of(input logic [CMD_W-1:0] c);
    if (c[CMD_WORD]) return SZ_WORD;
    if (c[CMD_HALF]) return SZ_HALF;
    return SZ_BYTE;
  endfunction

  function automatic logic [2:0] step_of(input xsize_e s);
    case (s)
      SZ_WORD: return 3'd4;
      SZ_HALF: return 3'd2;
      default: return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/dma2_chan.sv
module dma2_chan
  import dma2_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_addr,
  input  logic                wr_cnt,
  input  logic                wr_cmd,
  input  logic                rd_addr,
  input  logic [31:0]         wdata,
  input  logic                ev_ok,
  input  logic                ev_berr,
  input  logic                ev_align,
  input  logic                busy,
  output logic [ADDR_W-1:0]   addr_q,
  output logic [CNT_W-1:0]    cnt_q,
  output logic [CMD_W-1:0]    cmd_q,
  output logic [ST_W-1:0]     stat
);
  logic armed, pend, halt, berr, align_e, wrap;
  logic [ADDR_W:0] sum;

  assign sum  = {1'b0, addr_q} + {{(ADDR_W-2){1'b0}}, step_of(size_of(cmd_q))};
  assign stat = {wrap, align_e, berr, halt, busy, pend, armed};

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0; cnt_q <= '0; cmd_q <= '0;
      armed <= 1'b0; pend <= 1'b0; halt <= 1'b0;
      berr <= 1'b0; align_e <= 1'b0; wrap <= 1'b0;
    end else begin
      if (wr_addr && !armed) addr_q <= wdata[ADDR_W-1:0];
      if (wr_cnt && !armed)  cnt_q  <= wdata[CNT_W-1:0];
      if (rd_addr) pend <= 1'b0;
      if (ev_ok) begin
        addr_q <= sum[ADDR_W-1:0];
        if (sum[ADDR_W]) wrap <= 1'b1;
        if (cnt_q == '0) begin
          armed <= 1'b0;
          pend  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
      if (ev_berr) begin
        berr <= 1'b1; halt <= 1'b1; armed <= 1'b0; pend <= 1'b1;
      end
      if (ev_align) begin
        align_e <= 1'b1; halt <= 1'b1; armed <= 1'b0; pend <= 1'b1;
      end
      if (wr_cmd) begin
        cmd_q <= wdata[CMD_W-1:0] & ~(CMD_W'(1) << CMD_GO);
        armed <= wdata[CMD_GO];
        if (wdata[CMD_GO]) begin
          pend <= 1'b0; halt <= 1'b0; berr <= 1'b0;
          align_e <= 1'b0; wrap <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/dma2_arb.sv
module dma2_arb #(
  parameter int NCH   = 2,
  parameter int IDX_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0]   want,
  input  logic [NCH-1:0]   pri,
  output logic             gnt_v,
  output logic [IDX_W-1:0] gnt_idx
);
  always_comb begin
    gnt_v   = 1'b0;
    gnt_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (!gnt_v && want[i] && pri[i]) begin
        gnt_v   = 1'b1;
        gnt_idx = IDX_W'(i);
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (!gnt_v && want[i]) begin
        gnt_v   = 1'b1;
        gnt_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/dma2_irqenc.sv
module dma2_irqenc #(
  parameter int NCH = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCH-1:0]   pend,
  input  logic [NCH-1:0]   en,
  input  logic [2*NCH-1:0] code,
  output logic             irq,
  output logic [2:0]       irq_level
);
  logic       any;
  logic [2:0] best;

  always_comb begin
    any  = 1'b0;
    best = 3'd0;
    for (int i = 0; i < NCH; i++) begin
      if (pend[i] && en[i]) begin
        if (!any || (3'(code[2*i +: 2]) + 3'd3) > best) best = 3'(code[2*i +: 2]) + 3'd3;
        any = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
      irq_level <= 3'd0;
    end else begin
      irq <= any;
      irq_level <= best;
    end
  end
endmodule

// File: rtl/dma2ch_engine.sv
module dma2ch_engine
  import dma2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr,
  input  logic                  reg_rd,
  input  logic [$clog2(NCH)+1:0] reg_addr,
  input  logic [31:0]           reg_wdata,
  output logic [31:0]           reg_rdata,
  input  logic [NCH-1:0]        dev_rdy,
  input  logic [NCH*DATA_W-1:0] dev_din,
  output logic [NCH-1:0]        dev_ack,
  output logic [DATA_W-1:0]     dev_dout,
  output logic                  mem_req,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic                  mem_we,
  output logic [1:0]            mem_size,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic                  mem_gnt,
  input  logic                  mem_err,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic                  irq,
  output logic [2:0]            irq_level
);
  localparam int IDX_W = $clog2(NCH);

  logic [ADDR_W-1:0] ch_addr [NCH];
  logic [CNT_W-1:0]  ch_cnt  [NCH];
  logic [CMD_W-1:0]  ch_cmd  [NCH];
  logic [ST_W-1:0]   ch_stat [NCH];

  logic [NCH-1:0] want, pri, pend, en, busy;
  logic [NCH-1:0] ev_ok, ev_berr, ev_align;
  logic [2*NCH-1:0] code;

  logic [IDX_W-1:0] sel, win, cur;
  logic [1:0]       off;
  logic             arb_v, mis;
  xsize_e           win_sz;
  seq_e             state;

  assign sel = reg_addr[IDX_W+1:2];
  assign off = reg_addr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = (sel == IDX_W'(c));
    dma2_chan #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst      (rst),
      .wr_addr  (reg_wr && hit && off == 2'd0),
      .wr_cnt   (reg_wr && hit && off == 2'd1),
      .wr_cmd   (reg_wr && hit && off == 2'd3),
      .rd_addr  (reg_rd && hit && off == 2'd0),
      .wdata    (reg_wdata),
      .ev_ok    (ev_ok[c]),
      .ev_berr  (ev_berr[c]),
      .ev_align (ev_align[c]),
      .busy     (busy[c]),
      .addr_q   (ch_addr[c]),
      .cnt_q    (ch_cnt[c]),
      .cmd_q    (ch_cmd[c]),
      .stat     (ch_stat[c])
    );
    assign want[c] = ch_stat[c][ST_ARMED] && dev_rdy[c];
    assign pri[c]  = ch_cmd[c][CMD_PRI];
    assign pend[c] = ch_stat[c][ST_PEND];
    assign en[c]   = ch_cmd[c][CMD_EN];
    assign code[2*c +: 2] = ch_cmd[c][CMD_LVL +: 2];
    assign busy[c] = (state == SEQ_ACCESS) && (cur == IDX_W'(c));
  end

  dma2_arb #(.NCH(NCH), .IDX_W(IDX_W)) u_arb (
    .want    (want),
    .pri     (pri),
    .gnt_v   (arb_v),
    .gnt_idx (win)
  );

  dma2_irqenc #(.NCH(NCH)) u_irq (
    .clk       (clk),
    .rst       (rst),
    .pend      (pend),
    .en        (en),
    .code      (code),
    .irq       (irq),
    .irq_level (irq_level)
  );

  assign win_sz = size_of(ch_cmd[win]);
  assign mis = (win_sz == SZ_HALF && ch_addr[win][0]) ||
               (win_sz == SZ_WORD && ch_addr[win][1:0] != 2'b00);

  always_comb begin
    ev_ok = '0;
    ev_berr = '0;
    ev_align = '0;
    if (state == SEQ_ACCESS && mem_gnt) begin
      if (mem_err) ev_berr[cur] = 1'b1;
      else         ev_ok[cur]   = 1'b1;
    end
    if (state == SEQ_IDLE && arb_v && mis) ev_align[win] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= SEQ_IDLE;
      cur <= '0;
      mem_req <= 1'b0;
      mem_addr <= '0;
      mem_we <= 1'b0;
      mem_size <= 2'd0;
      mem_wdata <= '0;
      dev_ack <= '0;
      dev_dout <= '0;
    end else begin
      dev_ack <= '0;
      case (state)
        SEQ_IDLE: begin
          if (arb_v && !mis) begin
            state <= SEQ_ACCESS;
            cur <= win;
            mem_req <= 1'b1;
            mem_addr <= ch_addr[win];
            mem_we <= ch_cmd[win][CMD_TOMEM];
            mem_size <= win_sz;
            mem_wdata <= dev_din[win*DATA_W +: DATA_W];
          end
        end
        default: begin
          if (mem_gnt) begin
            state <= SEQ_IDLE;
            mem_req <= 1'b0;
            if (!mem_err) begin
              dev_ack[cur] <= 1'b1;
              if (!mem_we) dev_dout <= mem_rdata;
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (off)
        2'd0: reg_rdata <= 32'(ch_addr[sel]);
        2'd1: reg_rdata <= 32'(ch_cnt[sel]);
        2'd2: reg_rdata <= 32'(ch_stat[sel]);
        default: reg_rdata <= 32'(ch_cmd[sel]);
      endcase
    end
  end
endmodule

// File: rtl/dma2_chk.sv
module dma2_chk #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic              mem_err,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [1:0]        mem_size,
  input logic              mem_we,
  input logic [NCH-1:0]    dev_ack,
  input logic              irq,
  input logic [2:0]        irq_level
);
  // R10
  mem_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_size != 2'd3) && !(mem_size == 2'd1 && mem_addr[0]) &&
                !(mem_size == 2'd2 && mem_addr[1:0] != 2'b00));

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_gnt |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_size));

  // R6
  req_drop_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req && mem_gnt |=> !mem_req);

  // R5
  ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dev_ack));

  // R11
  ack_after_gnt_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_ack != '0) |-> $past(mem_req && mem_gnt && !mem_err));

  // R8
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (irq_level >= 3'd3) && (irq_level <= 3'd6));
endmodule

bind dma2ch_engine dma2_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_dma2_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_gnt   (mem_gnt),
  .mem_err   (mem_err),
  .mem_addr  (mem_addr),
  .mem_size  (mem_size),
  .mem_we    (mem_we),
  .dev_ack   (dev_ack),
  .irq       (irq),
  .irq_level (irq_level)
);

// File: tb/tb_dma2ch_engine.sv
`timescale 1ns/1ps
module tb_dma2ch_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [1:0]  dev_rdy = '0;
  logic [63:0] dev_din = '0;
  logic [1:0]  dev_ack;
  logic [31:0] dev_dout;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_gnt = 1'b0, mem_err = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        irq;
  logic [2:0]  irq_level;

  dma2ch_engine dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_rdy(dev_rdy), .dev_din(dev_din),
    .dev_ack(dev_ack), .dev_dout(dev_dout), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_gnt(mem_gnt),
    .mem_err(mem_err), .mem_rdata(mem_rdata), .irq(irq), .irq_level(irq_level)
  );

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  logic        hold = 1'b0, err_on = 1'b0;
  logic [31:0] err_addr = '0;
  int          wait_cnt = 0;
  logic [31:0] t_addr [64];
  logic [31:0] t_wdata [64];
  logic [1:0]  t_size [64];
  logic        t_we [64];
  int          n_txn = 0;
  logic [31:0] a_data [64];
  int          a_ch [64];
  int          n_ack = 0;

  function automatic logic [31:0] mem_model(input logic [31:0] a);
    return ~a ^ 32'h0F0F_0000;
  endfunction

  // memory model: grant after a random wait of 0..2 cycles
  always @(negedge clk) begin
    if (rst) begin
      mem_gnt = 1'b0;
      mem_err = 1'b0;
    end else if (mem_gnt) begin
      mem_gnt = 1'b0;
      mem_err = 1'b0;
    end else if (mem_req && !hold) begin
      if (wait_cnt == 0) begin
        mem_gnt = 1'b1;
        mem_err = err_on && (mem_addr == err_addr);
        mem_rdata = mem_model(mem_addr);
        if (n_txn < 64) begin
          t_addr[n_txn] = mem_addr; t_wdata[n_txn] = mem_wdata;
          t_size[n_txn] = mem_size; t_we[n_txn] = mem_we;
          n_txn++;
        end
        wait_cnt = $urandom % 3;
      end else begin
        wait_cnt--;
      end
    end
  end

  always @(negedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst && dev_ack[c] && n_ack < 64) begin
        a_ch[n_ack] = c; a_data[n_ack] = dev_dout; n_ack++;
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    reg_addr = {ch[0], off[1:0]}; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    reg_addr = {ch[0], off[1:0]}; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic arm(input int ch, input logic [31:0] a, input logic [31:0] n, input logic [31:0] cmd);
    wr(ch, 0, a);
    wr(ch, 1, n);
    wr(ch, 3, cmd | 32'h8000);
  endtask

  task automatic wait_done(input int ch, output logic [31:0] st);
    for (int i = 0; i < 3000; i++) begin
      rd(ch, 2, st);
      if (!st[0]) break;
    end
  endtask

  task automatic clr_logs();
    n_txn = 0; n_ack = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, st;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1", "reset mem_req", 32'(mem_req), 0);
    chk("R1", "reset irq", 32'(irq), 0);
    rd(0, 2, v); chk("R1", "reset status", v, 0);
    rd(1, 0, v); chk("R1", "reset addr ch1", v, 0);

    // byte write run, count 3 -> 4 transfers, enabled, level 5 (code 2)
    clr_logs();
    dev_din[31:0] = 32'hCAFE_0001;
    dev_rdy = 2'b01;
    arm(0, 32'h100, 3, 32'h0025);
    wait_done(0, st);
    chk("R3", "transfer count N=3", n_txn, 4);
    for (int k = 0; k < 4; k++) begin
      chk("R4", "byte address", t_addr[k], 32'h100 + k);
      chk("R4", "byte size code", 32'(t_size[k]), 0);
      chk("R5", "write direction", 32'(t_we[k]), 1);
      chk("R5", "write data", t_wdata[k], 32'hCAFE_0001);
    end
    chk("R5", "ack count", n_ack, 4);
    chk("R7", "done status", st, 32'h02);
    chk("R7", "irq enabled", 32'(irq), 1);
    chk("R8", "irq level", 32'(irq_level), 5);
    rd(0, 1, v); chk("R3", "count after run", v, 0);
    rd(0, 0, v); chk("R4", "final address", v, 32'h104);
    @(negedge clk);
    chk("R9", "irq after addr read", 32'(irq), 0);
    rd(0, 2, v); chk("R9", "pending cleared", v, 0);

    // halfword read run, enable off
    clr_logs();
    arm(0, 32'h200, 2, 32'h0002);
    wait_done(0, st);
    chk("R3", "halfword count", n_txn, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R4", "halfword address", t_addr[k], 32'h200 + 2 * k);
      chk("R4", "halfword size", 32'(t_size[k]), 1);
      chk("R5", "read direction", 32'(t_we[k]), 0);
      chk("R5", "dev_dout data", a_data[k], mem_model(32'h200 + 2 * k));
    end
    chk("R7", "pending without enable", st, 32'h02);
    chk("R7", "irq stays low", 32'(irq), 0);
    rd(0, 0, v); chk("R4", "halfword final", v, 32'h206);

    // word size takes precedence over halfword bit
    clr_logs();
    arm(0, 32'h300, 1, 32'h0102);
    wait_done(0, st);
    chk("R4", "word count", n_txn, 2);
    chk("R4", "word size", 32'(t_size[1]), 2);
    chk("R4", "word address 2", t_addr[1], 32'h304);
    rd(0, 0, v); chk("R4", "word final", v, 32'h308);

    // misaligned word start
    clr_logs();
    arm(0, 32'h302, 0, 32'h0101);
    wait_done(0, st);
    chk("R10", "no access", n_txn, 0);
    chk("R10", "align status", st, 32'h2A);
    rd(0, 0, v); chk("R10", "address kept", v, 32'h302);

    // bus error on third byte
    clr_logs();
    err_on = 1'b1; err_addr = 32'h402;
    arm(0, 32'h400, 5, 32'h0000);
    wait_done(0, st);
    err_on = 1'b0;
    chk("R11", "accesses until error", n_txn, 3);
    chk("R11", "acks before error", n_ack, 2);
    chk("R11", "berr status", st, 32'h1A);
    rd(0, 0, v); chk("R11", "address not advanced", v, 32'h402);

    // wrap past top of address space
    clr_logs();
    arm(0, 32'hFFFF_FFFC, 3, 32'h0002);
    wait_done(0, st);
    chk("R12", "wrap transfers", n_txn, 4);
    chk("R12", "wrapped address", t_addr[2], 32'h0);
    chk("R12", "wrap status", st, 32'h42);
    rd(0, 0, v); chk("R12", "final after wrap", v, 32'h4);

    // arming clears flags, disarm, writes ignored while armed, busy bit
    dev_rdy = 2'b00;
    arm(0, 32'h10, 0, 32'h0000);
    rd(0, 2, v); chk("R2", "armed clears old flags", v, 32'h01);
    wr(0, 3, 32'h0000);
    rd(0, 2, v); chk("R2", "disarmed", v, 32'h00);
    clr_logs();
    dev_rdy = 2'b01;
    repeat (4) @(negedge clk);
    chk("R2", "no transfer when disarmed", n_txn, 0);
    dev_rdy = 2'b10;
    hold = 1'b1;
    arm(1, 32'h500, 0, 32'h0000);
    repeat (3) @(negedge clk);
    rd(1, 2, v); chk("R14", "access in progress", v, 32'h05);
    wr(1, 0, 32'h900);
    wr(1, 1, 32'h7);
    rd(1, 0, v); chk("R2", "addr write ignored", v, 32'h500);
    rd(1, 1, v); chk("R2", "count write ignored", v, 32'h0);
    hold = 1'b0;
    wait_done(1, st);
    chk("R6", "single granted access", n_txn, 1);
    chk("R6", "granted address", t_addr[0], 32'h500);
    rd(1, 0, v);

    // priority bit wins; merged irq level
    dev_rdy = 2'b00;
    clr_logs();
    arm(0, 32'h600, 0, 32'h0011);
    arm(1, 32'h700, 0, 32'h0039);
    dev_rdy = 2'b11;
    wait_done(0, st);
    wait_done(1, st);
    chk("R13", "priority channel first", t_addr[0], 32'h700);
    chk("R8", "highest level", 32'(irq_level), 6);
    rd(1, 0, v);
    @(negedge clk);
    chk("R8", "remaining level", 32'(irq_level), 4);
    chk("R9", "irq still from ch0", 32'(irq), 1);
    rd(0, 0, v);
    @(negedge clk);
    chk("R9", "irq cleared", 32'(irq), 0);

    // equal priority: channel 0 first
    dev_rdy = 2'b00;
    clr_logs();
    arm(0, 32'h800, 0, 32'h0000);
    arm(1, 32'h880, 0, 32'h0000);
    dev_rdy = 2'b11;
    wait_done(0, st);
    wait_done(1, st);
    chk("R13", "tie goes to ch0", t_addr[0], 32'h800);
    dev_rdy = 2'b01;

    // random runs on channel 0
    for (int it = 0; it < 20; it++) begin
      int sz, n, dir;
      logic [31:0] base, cmd;
      sz = $urandom % 3; n = $urandom % 5; dir = $urandom % 2;
      base = 32'h1000 + ($urandom % 256) * 4;
      cmd = (sz == 2) ? 32'h100 : (sz == 1 ? 32'h2 : 32'h0);
      if (dir == 1) cmd = cmd | 32'h4;
      dev_din[31:0] = $urandom;
      clr_logs();
      arm(0, base, n, cmd);
      wait_done(0, st);
      chk("R3", "random count", n_txn, n + 1);
      for (int k = 0; k <= n; k++) begin
        chk("R4", "random address", t_addr[k], base + k * (1 << sz));
        chk("R4", "random size", 32'(t_size[k]), sz);
        chk("R5", "random dir", 32'(t_we[k]), dir);
        if (dir == 0) chk("R5", "random read data", a_data[k], mem_model(base + k * (1 << sz)));
      end
      chk("R7", "random status", st, 32'h02);
      rd(0, 0, v); chk("R4", "random final", v, base + (n + 1) * (1 << sz));
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule